// File: doc/BRIEF.md
# Redirection-Entry Interrupt Message Dispatcher

This block watches a bank of external interrupt lines and turns each new low-to-high transition into one or more interrupt messages. Each line owns a redirection entry. The register block that owns the entry table drives the entries in as a flat input vector. An entry decides whether the event is dropped, which vector is sent, how the message is delivered and where it goes. Edges that arrive while the block is busy are latched per line. They are served in fixed priority, with the lowest line number first.

Messages leave over a valid/ready port. Back-pressure rules: once `msg_valid_o` rises, every message field holds its value until a cycle in which `msg_ready_i` is high. That cycle is the handshake, and the message is consumed at its clock edge. Ready may be held high at any time and may rise before valid. Ready has no effect while valid is low. A logical-mode entry is expanded into one message per set bit of its destination bitmask. These messages go out back to back, one per accepted handshake.

Entries in the external-legacy delivery mode get their vector from an outside legacy controller. The block sends a one-cycle request strobe, waits for the controller's vector-valid response, and only then offers the message. A reserved delivery mode never produces a message. It raises a sticky fatal output instead.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `msg_valid_o`, `vec_req_o` and `fatal_o` are low, and no line is pending.
- R2: Only a low-to-high transition of a line creates an event. A line held high creates nothing further. Lowering a line creates nothing. Lowering and raising it again creates a new event.
- R3: The entry layout is: bits 7:0 vector, 10:8 delivery mode, 11 destination mode (1 = logical), 12 polarity, 13 trigger, 14 mask, 22:15 destination. Entry `l` sits at `tbl_i[23*l +: 23]`. An edge on a line whose mask bit is 1 at the edge is dropped, and no message results.
- R4: A message copies the entry's delivery mode to `msg_mode_o`, destination mode to `msg_dmode_o`, polarity to `msg_level_o` and trigger to `msg_trig_o`. For every mode other than 7, `msg_vector_o` is the entry's vector field.
- R5: For delivery mode 7 (external legacy), `vec_req_o` is high for exactly one cycle. The message is withheld until `vec_valid_i` is seen high in a later cycle, and `msg_vector_o` then carries the `vec_i` sampled with it.
- R6: Delivery modes 3 and 6 are reserved. Such an event sends no message and sets `fatal_o`, which stays high until reset. Later events are still served.
- R7: Destination mode 0 (physical) sends exactly one message, with `msg_dest_o` equal to the entry's destination field.
- R8: Destination mode 1 (logical) sends one message for each set bit i of the destination field, in rising order of i, with `msg_dest_o` = i. A zero bitmask sends nothing.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, valid stays high and all message fields stay unchanged.
- R10: When several lines are pending, the lowest-numbered line is served first.
- R11: If a line rises again in the same cycle that its pending event is taken for service, the new event is kept and served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_LINES | Interrupt input lines |
| tbl_i | input | NUM_LINES*23 | Redirection entries, 23 bits per line |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Receiver accepts message |
| msg_dest_o | output | 8 | Target ID |
| msg_vector_o | output | 8 | Interrupt vector |
| msg_mode_o | output | 3 | Delivery mode |
| msg_dmode_o | output | 1 | Destination mode (1 = logical) |
| msg_level_o | output | 1 | Level bit from entry polarity |
| msg_trig_o | output | 1 | Trigger bit from entry |
| vec_req_o | output | 1 | One-cycle vector request to legacy controller |
| vec_valid_i | input | 1 | Legacy controller vector valid |
| vec_i | input | 8 | Vector from legacy controller |
| fatal_o | output | 1 | Sticky reserved-mode error |

## Verification
Two things can happen on the same clock edge: the sequencer clears a line's pending bit when it takes that event, and the edge detector sets the same bit because the line rose again. To provoke this, the bench stalls the port on one message while a second line goes high and then low, so that its event is latched. It then accepts the stalled message and raises the second line again in the very cycle the sequencer takes that line's event. The test passes only if that line then produces two complete messages and nothing after them.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;
  localparam int ENT_W  = VEC_W + MODE_W + 4 + DEST_W;

  // Entry layout, LSB first: vector, mode, logical, polarity, trigger, mask, dest
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              logical;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } redir_ent_t;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV_A  = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV_B  = 3'd6,
    DM_LEGACY = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_VREQ  = 2'd1,
    S_VWAIT = 2'd2,
    S_SEND  = 2'd3
  } seq_e;

  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    return (m == DM_RSV_A) || (m == DM_RSV_B);
  endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    any_o    = |req_i;
    onehot_o = req_i & (~req_i + N'(1));
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;
  logic [N-1:0] set_ev;

  always_comb begin
    rise   = irq_i & ~prev_q;
    set_ev = rise & ~mask_i;
  end

  // set wins over clear so a fresh edge in the take cycle is kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_i;
      pend_q <= (pend_q & ~clr_i) | set_ev;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_msg_seq.sv
module irq_msg_seq
  import irqd_pkg::*;
#(
  parameter int DW = DEST_W,
  parameter int VW = VEC_W,
  localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [VW-1:0]     ent_vec_i,
  input  logic [MODE_W-1:0] ent_mode_i,
  input  logic              ent_logical_i,
  input  logic              ent_pol_i,
  input  logic              ent_trig_i,
  input  logic [DW-1:0]     ent_dest_i,
  output logic              take_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [DW-1:0]     msg_dest_o,
  output logic [VW-1:0]     msg_vector_o,
  output logic [MODE_W-1:0] msg_mode_o,
  output logic              msg_dmode_o,
  output logic              msg_level_o,
  output logic              msg_trig_o,
  output logic              vec_req_o,
  input  logic              vec_valid_i,
  input  logic [VW-1:0]     vec_i,
  output logic              fatal_o
);
  seq_e              st_q;
  logic [DW-1:0]     dest_q;
  logic [DW-1:0]     rem_q;
  logic [VW-1:0]     vec_q;
  logic [MODE_W-1:0] mode_q;
  logic              logical_q;
  logic              pol_q;
  logic              trig_q;
  logic              fatal_q;

  logic              scan_any;
  logic [CW-1:0]     cur_idx;
  logic [DW-1:0]     cur_oh;
  logic [DW-1:0]     rem_nxt;
  logic              hs;

  irq_prio_pick #(.N(DW)) u_scan (
    .req_i    (rem_q),
    .any_o    (scan_any),
    .idx_o    (cur_idx),
    .onehot_o (cur_oh)
  );

  always_comb begin
    take_o      = (st_q == S_IDLE) && any_i;
    msg_valid_o = (st_q == S_SEND) && (!logical_q || scan_any);
    hs          = msg_valid_o && msg_ready_i;
    rem_nxt     = rem_q & ~cur_oh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      dest_q    <= '0;
      rem_q     <= '0;
      vec_q     <= '0;
      mode_q    <= '0;
      logical_q <= 1'b0;
      pol_q     <= 1'b0;
      trig_q    <= 1'b0;
      fatal_q   <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (any_i) begin
            dest_q    <= ent_dest_i;
            rem_q     <= ent_dest_i;
            vec_q     <= ent_vec_i;
            mode_q    <= ent_mode_i;
            logical_q <= ent_logical_i;
            pol_q     <= ent_pol_i;
            trig_q    <= ent_trig_i;
            if (mode_reserved(ent_mode_i)) begin
              fatal_q <= 1'b1;
            end else if (ent_logical_i && (ent_dest_i == '0)) begin
              st_q <= S_IDLE;
            end else if (ent_mode_i == DM_LEGACY) begin
              st_q <= S_VREQ;
            end else begin
              st_q <= S_SEND;
            end
          end
        end
        S_VREQ: st_q <= S_VWAIT;
        S_VWAIT: begin
          if (vec_valid_i) begin
            vec_q <= vec_i;
            st_q  <= S_SEND;
          end
        end
        S_SEND: begin
          if (hs) begin
            rem_q <= rem_nxt;
            if (!logical_q || (rem_nxt == '0)) st_q <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    msg_dest_o   = logical_q ? DW'(cur_idx) : dest_q;
    msg_vector_o = vec_q;
    msg_mode_o   = mode_q;
    msg_dmode_o  = logical_q;
    msg_level_o  = pol_q;
    msg_trig_o   = trig_q;
    vec_req_o    = (st_q == S_VREQ);
    fatal_o      = fatal_q;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_LINES = 24,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       irq_i,
  input  logic [NUM_LINES*ENT_W-1:0] tbl_i,
  output logic                       msg_valid_o,
  input  logic                       msg_ready_i,
  output logic [DEST_W-1:0]          msg_dest_o,
  output logic [VEC_W-1:0]           msg_vector_o,
  output logic [MODE_W-1:0]          msg_mode_o,
  output logic                       msg_dmode_o,
  output logic                       msg_level_o,
  output logic                       msg_trig_o,
  output logic                       vec_req_o,
  input  logic                       vec_valid_i,
  input  logic [VEC_W-1:0]           vec_i,
  output logic                       fatal_o
);
  redir_ent_t           ent_arr [NUM_LINES];
  logic [NUM_LINES-1:0] mask_vec;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] pick_oh;
  logic [NUM_LINES-1:0] clr;
  logic [LW-1:0]        pick_idx;
  logic                 pick_any;
  logic                 take;
  redir_ent_t           sel_ent;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_unpack
    assign ent_arr[l]  = redir_ent_t'(tbl_i[l*ENT_W +: ENT_W]);
    assign mask_vec[l] = ent_arr[l].mask;
  end

  irq_edge_latch #(.N(NUM_LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_i),
    .mask_i (mask_vec),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_prio_pick #(.N(NUM_LINES)) u_pick (
    .req_i    (pend),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  always_comb begin
    sel_ent = ent_arr[pick_idx];
    clr     = take ? pick_oh : '0;
  end

  irq_msg_seq #(.DW(DEST_W), .VW(VEC_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .any_i         (pick_any),
    .ent_vec_i     (sel_ent.vec),
    .ent_mode_i    (sel_ent.mode),
    .ent_logical_i (sel_ent.logical),
    .ent_pol_i     (sel_ent.pol),
    .ent_trig_i    (sel_ent.trig),
    .ent_dest_i    (sel_ent.dest),
    .take_o        (take),
    .msg_valid_o   (msg_valid_o),
    .msg_ready_i   (msg_ready_i),
    .msg_dest_o    (msg_dest_o),
    .msg_vector_o  (msg_vector_o),
    .msg_mode_o    (msg_mode_o),
    .msg_dmode_o   (msg_dmode_o),
    .msg_level_o   (msg_level_o),
    .msg_trig_o    (msg_trig_o),
    .vec_req_o     (vec_req_o),
    .vec_valid_i   (vec_valid_i),
    .vec_i         (vec_i),
    .fatal_o       (fatal_o)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irqd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [DEST_W-1:0] msg_dest_o,
  input logic [VEC_W-1:0]  msg_vector_o,
  input logic [MODE_W-1:0] msg_mode_o,
  input logic              msg_dmode_o,
  input logic              msg_level_o,
  input logic              msg_trig_o,
  input logic              vec_req_o,
  input logic              fatal_o
);
  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> msg_valid_o);

  // R9
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> ($stable(msg_dest_o) && $stable(msg_vector_o)
      && $stable(msg_mode_o) && $stable(msg_dmode_o) && $stable(msg_level_o)
      && $stable(msg_trig_o)));

  // R5
  vreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |=> !vec_req_o);

  // R5
  vreq_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> !msg_valid_o);

  // R6
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> fatal_o);

  // R6
  no_reserved_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> !mode_reserved(msg_mode_o));

  // R8
  logical_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && msg_dmode_o) |-> (msg_dest_o < DEST_W));
endmodule

bind irq_dispatch irq_dispatch_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_valid_o  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .msg_dest_o   (msg_dest_o),
  .msg_vector_o (msg_vector_o),
  .msg_mode_o   (msg_mode_o),
  .msg_dmode_o  (msg_dmode_o),
  .msg_level_o  (msg_level_o),
  .msg_trig_o   (msg_trig_o),
  .vec_req_o    (vec_req_o),
  .fatal_o      (fatal_o)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
  localparam int NL = 24;
  localparam int EW = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq = '0;
  logic [NL*EW-1:0] tbl = '0;
  logic          msg_valid, msg_ready = 1'b0;
  logic [7:0]    msg_dest, msg_vector;
  logic [2:0]    msg_mode;
  logic          msg_dmode, msg_level, msg_trig;
  logic          vec_req, vec_valid = 1'b0;
  logic [7:0]    vec_in = '0;
  logic          fatal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_dispatch #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .tbl_i(tbl),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_dest_o(msg_dest), .msg_vector_o(msg_vector), .msg_mode_o(msg_mode),
    .msg_dmode_o(msg_dmode), .msg_level_o(msg_level), .msg_trig_o(msg_trig),
    .vec_req_o(vec_req), .vec_valid_i(vec_valid), .vec_i(vec_in), .fatal_o(fatal)
  );

  function automatic logic [EW-1:0] mk(input logic [7:0] dest, input logic msk,
      input logic trg, input logic pol, input logic dm, input logic [2:0] mode,
      input logic [7:0] vec);
    return {dest, msk, trg, pol, dm, mode, vec};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ent(input int l, input logic [EW-1:0] e);
    tbl[l*EW +: EW] = e;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq = '0; msg_ready = 1'b0; vec_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    irq = '0;
    repeat (3) @(negedge clk);
  endtask

  // waits for a message, compares all fields, then accepts it
  task automatic wait_msg(input logic [7:0] dest, input logic [7:0] vec,
      input logic [2:0] mode, input logic dm, input logic lvl, input logic trg,
      input string req);
    int n = 0;
    while (!msg_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(msg_valid && {msg_dest, msg_vector, msg_mode, msg_dmode, msg_level, msg_trig}
          == {dest, vec, mode, dm, lvl, trg}, req,
        {10'd0, msg_dest, msg_vector, msg_mode, msg_dmode, msg_level, msg_trig},
        {10'd0, dest, vec, mode, dm, lvl, trg});
    msg_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk({msg_valid, vec_req, fatal} == 3'b000, "R1 outputs after reset",
        {msg_valid, vec_req, fatal}, 0);
    expect_quiet(5, "R1 nothing pending after reset");
  endtask

  task automatic t_physical();
    set_ent(3, mk(8'h2A, 0, 1, 0, 0, 3'd0, 8'h41));
    @(negedge clk); irq[3] = 1'b1;
    wait_msg(8'h2A, 8'h41, 3'd0, 0, 0, 1, "R7 R4 physical message");
    expect_quiet(8, "R7 single message");
    settle();
  endtask

  task automatic t_logical();
    set_ent(6, mk(8'hA5, 0, 0, 1, 1, 3'd1, 8'h66));
    @(negedge clk); irq[6] = 1'b1;
    wait_msg(8'd0, 8'h66, 3'd1, 1, 1, 0, "R8 R4 logical target 0");
    wait_msg(8'd2, 8'h66, 3'd1, 1, 1, 0, "R8 logical target 2");
    wait_msg(8'd5, 8'h66, 3'd1, 1, 1, 0, "R8 logical target 5");
    wait_msg(8'd7, 8'h66, 3'd1, 1, 1, 0, "R8 logical target 7");
    expect_quiet(8, "R8 fanout ends");
    set_ent(10, mk(8'h00, 0, 0, 0, 1, 3'd0, 8'h70));
    @(negedge clk); irq[10] = 1'b1;
    expect_quiet(10, "R8 zero bitmask sends nothing");
    settle();
  endtask

  task automatic t_edge();
    set_ent(12, mk(8'h05, 0, 0, 0, 0, 3'd4, 8'h02));
    @(negedge clk); irq[12] = 1'b1;
    wait_msg(8'h05, 8'h02, 3'd4, 0, 0, 0, "R2 first rise");
    expect_quiet(12, "R2 held high gives no event");
    @(negedge clk); irq[12] = 1'b0;
    expect_quiet(6, "R2 falling gives no event");
    irq[12] = 1'b1;
    wait_msg(8'h05, 8'h02, 3'd4, 0, 0, 0, "R2 re-raise gives event");
    settle();
  endtask

  task automatic t_mask();
    set_ent(14, mk(8'h09, 1, 0, 0, 0, 3'd0, 8'h30));
    @(negedge clk); irq[14] = 1'b1;
    expect_quiet(6, "R3 masked edge dropped");
    set_ent(14, mk(8'h09, 0, 0, 0, 0, 3'd0, 8'h30));
    expect_quiet(6, "R3 unmask later gives no message");
    settle();
  endtask

  task automatic t_legacy();
    int n = 0;
    set_ent(2, mk(8'h03, 0, 1, 1, 0, 3'd7, 8'h11));
    @(negedge clk); irq[2] = 1'b1;
    while (!vec_req && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(vec_req, "R5 vector request seen", vec_req, 1);
    @(negedge clk);
    chk(!vec_req && !msg_valid, "R5 strobe one cycle, no message yet",
        {vec_req, msg_valid}, 0);
    repeat (3) @(negedge clk);
    chk(!msg_valid, "R5 waits for vector valid", msg_valid, 0);
    vec_valid = 1'b1; vec_in = 8'h5C;
    @(negedge clk);
    vec_valid = 1'b0; vec_in = 8'h00;
    wait_msg(8'h03, 8'h5C, 3'd7, 0, 1, 1, "R5 vector from legacy controller");
    settle();
  endtask

  task automatic t_stall();
    logic [21:0] snap;
    int bad = 0;
    int n = 0;
    set_ent(1, mk(8'h09, 0, 1, 1, 0, 3'd0, 8'h77));
    @(negedge clk); irq[1] = 1'b1;
    while (!msg_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    snap = {msg_dest, msg_vector, msg_mode, msg_dmode, msg_level, msg_trig};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!msg_valid || snap != {msg_dest, msg_vector, msg_mode, msg_dmode,
                                 msg_level, msg_trig}) bad++;
    end
    chk(bad == 0, "R9 held under back-pressure", bad, 0);
    wait_msg(8'h09, 8'h77, 3'd0, 0, 1, 1, "R9 accepted after stall");
    settle();
  endtask

  task automatic t_prio();
    set_ent(4, mk(8'h14, 0, 0, 0, 0, 3'd0, 8'h44));
    set_ent(9, mk(8'h19, 0, 0, 0, 0, 3'd0, 8'h99));
    @(negedge clk); irq[9] = 1'b1; irq[4] = 1'b1;
    wait_msg(8'h14, 8'h44, 3'd0, 0, 0, 0, "R10 lower line first");
    wait_msg(8'h19, 8'h99, 3'd0, 0, 0, 0, "R10 higher line second");
    settle();
  endtask

  task automatic t_collide();
    int n = 0;
    set_ent(0, mk(8'h01, 0, 0, 0, 0, 3'd0, 8'h20));
    set_ent(5, mk(8'h02, 0, 0, 0, 0, 3'd0, 8'h25));
    @(negedge clk); irq[0] = 1'b1;
    while (!msg_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    irq[5] = 1'b1;
    @(negedge clk); irq[5] = 1'b0;
    @(negedge clk);
    chk(msg_dest == 8'h01, "R11 stalled line 0 message", msg_dest, 8'h01);
    msg_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msg_ready = 1'b0;
    irq[5] = 1'b1;
    wait_msg(8'h02, 8'h25, 3'd0, 0, 0, 0, "R11 latched event served");
    wait_msg(8'h02, 8'h25, 3'd0, 0, 0, 0, "R11 same-cycle rise kept");
    expect_quiet(8, "R11 no extra message");
    settle();
  endtask

  task automatic t_reserved();
    do_reset();
    set_ent(4, mk(8'h04, 0, 0, 0, 0, 3'd3, 8'h31));
    @(negedge clk); irq[4] = 1'b1;
    expect_quiet(8, "R6 mode 3 sends nothing");
    chk(fatal, "R6 mode 3 raises fatal", fatal, 1);
    settle();
    do_reset();
    chk(!fatal, "R6 fatal cleared by reset", fatal, 0);
    set_ent(7, mk(8'h07, 0, 0, 0, 0, 3'd6, 8'h32));
    set_ent(8, mk(8'h08, 0, 0, 0, 0, 3'd5, 8'h33));
    @(negedge clk); irq[7] = 1'b1; irq[8] = 1'b1;
    wait_msg(8'h08, 8'h33, 3'd5, 0, 0, 0, "R6 later event still served");
    chk(fatal, "R6 mode 6 raises fatal and holds", fatal, 1);
    settle();
  endtask

  initial begin
    t_reset();
    t_physical();
    t_logical();
    t_edge();
    t_mask();
    t_legacy();
    t_stall();
    t_prio();
    t_collide();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule